// File: doc/BRIEF.md
# Cartridge Bank-Switching Mapper

This block sits between a console CPU bus and a video (picture-processor) bus. Writes from the CPU to a small register window near 0x7EF0 load six character bank registers, three program bank registers and a two-bit control register. Every CPU read in the upper 32 KB and every video access in the lowest 8 KB is turned, in the same cycle, into a physical ROM or RAM address. The block also drives the nametable mirroring select.

The program space is split into four 8 KB windows. Three can be switched and the top one is fixed to the last bank. The character space has two 2 KB banks and four 1 KB banks. A control bit can swap its two 4 KB halves. Bank counts are powers of two, so wrapping a bank number is a mask. When the character memory is configured as RAM, it is 8 KB deep and video writes are passed through to it as a write enable.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the character registers 0..5 hold 0, 2, 4, 5, 6, 7, the program registers for windows 0x8000/0xA000/0xC000 hold 0, 1, 2, the control register holds 0 and mirrorVert is 0.
- R2: A CPU write to 0x7EF0 + n (n = 0..5) loads character register n with the full data byte on the next rising clock edge.
- R3: A CPU write to 0x7EF6 keeps data bits 1:0 as control. mirrorVert equals control bit 0 (1 = vertical, 0 = horizontal).
- R4: CPU writes to 0x7EFA, 0x7EFB and 0x7EFC store data >> 2 as the 8 KB bank for CPU windows 0x8000, 0xA000 and 0xC000. prgAddr = bank * 0x2000 + (cpuAddr & 0x1FFF).
- R5: The window 0xE000..0xFFFF always maps to the last 8 KB program bank.
- R6: Video regions 0x0000..0x07FF and 0x0800..0x0FFF use 2 KB bank numbers (register 0 >> 1) and (register 1 >> 1), with a 11-bit offset. The 1 KB regions at 0x1000, 0x1400, 0x1800 and 0x1C00 use registers 2, 3, 4 and 5 directly, with a 10-bit offset.
- R7: With control bit 1 set, the region is chosen from the video address with bit 12 inverted. The in-bank offset still comes from the unmodified address.
- R8: Every bank number wraps modulo the number of banks of its size (a power of two). In RAM mode there are 8 banks of 1 KB and 4 banks of 2 KB.
- R9: prgHit is 1 exactly when cpuAddr >= 0x8000. chrHit is 1 exactly when vidAddr < 0x2000.
- R10: chrRamWe is 1 only in RAM mode, when vidWrEn is high and chrHit is 1. In ROM mode it is always 0.
- R11: CPU writes to any other address (0x7EF7..0x7EF9, 0x7EFD..0x7EFF, and addresses outside the window) change no register, mapping or mirroring.
- R12: A translation in the cycle of a register write uses the old register value. The new value is used from the cycle after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| cpuWrEn | input | 1 | CPU write strobe |
| vidAddr | input | 14 | Video-bus address |
| vidWrEn | input | 1 | Video-bus write strobe |
| prgAddr | output | PRG_AW | Physical program ROM address |
| prgHit | output | 1 | CPU address falls in program space |
| chrAddr | output | CHR_AW | Physical character memory address |
| chrHit | output | 1 | Video address falls in character space |
| chrRamWe | output | 1 | Character RAM write enable |
| mirrorVert | output | 1 | 1 = vertical mirroring, 0 = horizontal |

## Verification
Two functions can fall in the same cycle: a character register write and a video translation or RAM write that goes through that same register. The bench drives a write to character register 0 and a video write into region 0 together. Before the clock edge it expects the old bank on chrAddr with chrRamWe high, and after the edge it expects the new bank. A second pair of DUT instances is not needed, because a ROM-mode and a RAM-mode instance share every input and are judged against the same arithmetic model.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  typedef struct packed {
    logic [5:0] chrLoad;
    logic [2:0] prgLoad;
    logic       ctlLoad;
    logic [7:0] data;
  } regStrobe_t;

  localparam logic [11:0] REG_WINDOW = 12'h7EF;

  function automatic logic [7:0] chrResetVal(input int idx);
    case (idx)
      0:       return 8'd0;
      1:       return 8'd2;
      2:       return 8'd4;
      3:       return 8'd5;
      4:       return 8'd6;
      default: return 8'd7;
    endcase
  endfunction

endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import mapper_pkg::*;
#(
  parameter bit CHR_IS_RAM = 1'b0
) (
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuData,
  input  logic        cpuWrEn,
  input  logic        vidWrEn,
  input  logic        chrHit,
  output regStrobe_t  strobe,
  output logic        chrRamWe
);

  logic inWindow;
  assign inWindow = (cpuAddr[15:4] == REG_WINDOW);

  always_comb begin
    strobe      = '0;
    strobe.data = cpuData;
    if (cpuWrEn && inWindow) begin
      case (cpuAddr[3:0])
        4'h0, 4'h1, 4'h2,
        4'h3, 4'h4, 4'h5: strobe.chrLoad[cpuAddr[2:0]] = 1'b1;
        4'h6:             strobe.ctlLoad = 1'b1;
        4'hA:             strobe.prgLoad[0] = 1'b1;
        4'hB:             strobe.prgLoad[1] = 1'b1;
        4'hC:             strobe.prgLoad[2] = 1'b1;
        default:          ;
      endcase
    end
  end

  generate
    if (CHR_IS_RAM) begin : g_ram
      assign chrRamWe = vidWrEn & chrHit;
    end else begin : g_rom
      assign chrRamWe = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/mapper_datapath.sv
module mapper_datapath
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS = 8,
  parameter int CHR_BANKS = 16,
  localparam int PRG_BW = $clog2(PRG_BANKS),
  localparam int CHR_BW = $clog2(CHR_BANKS),
  localparam int PRG_AW = PRG_BW + 13,
  localparam int CHR_AW = CHR_BW + 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [15:0]       cpuAddr,
  input  logic [13:0]       vidAddr,
  output logic [PRG_AW-1:0] prgAddr,
  output logic              prgHit,
  output logic [CHR_AW-1:0] chrAddr,
  output logic              chrHit,
  output logic              mirrorVert
);

  logic [5:0][7:0] chrReg;
  logic [2:0][7:0] prgReg;
  logic [1:0]      ctlReg;

  genvar gi;
  generate
    for (gi = 0; gi < 6; gi++) begin : g_chr
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   chrReg[gi] <= chrResetVal(gi);
        else if (strobe.chrLoad[gi]) chrReg[gi] <= strobe.data;
      end
    end
    for (gi = 0; gi < 3; gi++) begin : g_prg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   prgReg[gi] <= 8'(gi);
        else if (strobe.prgLoad[gi]) prgReg[gi] <= {2'b00, strobe.data[7:2]};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ctlReg <= 2'b00;
    else if (strobe.ctlLoad) ctlReg <= strobe.data[1:0];
  end

  assign mirrorVert = ctlReg[0];

  // program side: four 8 KB windows, the top one pinned to the last bank
  logic [PRG_BW-1:0] prgBank;
  always_comb begin
    case (cpuAddr[14:13])
      2'd0:    prgBank = prgReg[0][PRG_BW-1:0];
      2'd1:    prgBank = prgReg[1][PRG_BW-1:0];
      2'd2:    prgBank = prgReg[2][PRG_BW-1:0];
      default: prgBank = '1;
    endcase
  end
  assign prgAddr = {prgBank, cpuAddr[12:0]};
  assign prgHit  = cpuAddr[15];

  // character side: region picked on the possibly swapped address
  logic [2:0] region;
  logic [7:0] chrSel;
  assign region = vidAddr[12:10] ^ {ctlReg[1], 2'b00};
  assign chrHit = ~vidAddr[13];

  always_comb begin
    if (!region[2]) begin
      chrSel  = chrReg[{2'b00, region[1]}];
      chrAddr = {chrSel[CHR_BW-1:1], vidAddr[10:0]};
    end else begin
      chrSel  = chrReg[3'd2 + {1'b0, region[1:0]}];
      chrAddr = {chrSel[CHR_BW-1:0], vidAddr[9:0]};
    end
  end

  // R2
  chr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.chrLoad[2] |=> chrReg[2] == $past(strobe.data));

  // R3
  mirror_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ctlLoad |=> mirrorVert == $past(strobe.data[0]));

  // R4
  prg_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.prgLoad[1] |=> prgReg[1] == {2'b00, $past(strobe.data[7:2])});

  // R5
  fixed_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prgHit && cpuAddr[14:13] == 2'b11) |-> prgAddr[PRG_AW-1:13] == '1);

  // R11
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|{strobe.chrLoad, strobe.prgLoad, strobe.ctlLoad})
      |=> ($stable(chrReg) && $stable(prgReg) && $stable(ctlReg)));

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS   = 8,
  parameter int CHR_BANKS_1K = 16,
  parameter bit CHR_IS_RAM  = 1'b0,
  localparam int CHR_EFF = CHR_IS_RAM ? 8 : CHR_BANKS_1K,
  localparam int PRG_AW  = $clog2(PRG_BANKS) + 13,
  localparam int CHR_AW  = $clog2(CHR_EFF) + 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        cpuData,
  input  logic              cpuWrEn,
  input  logic [13:0]       vidAddr,
  input  logic              vidWrEn,
  output logic [PRG_AW-1:0] prgAddr,
  output logic              prgHit,
  output logic [CHR_AW-1:0] chrAddr,
  output logic              chrHit,
  output logic              chrRamWe,
  output logic              mirrorVert
);

  regStrobe_t strobe;

  mapper_ctrl #(.CHR_IS_RAM(CHR_IS_RAM)) u_ctrl (
    .cpuAddr (cpuAddr),
    .cpuData (cpuData),
    .cpuWrEn (cpuWrEn),
    .vidWrEn (vidWrEn),
    .chrHit  (chrHit),
    .strobe  (strobe),
    .chrRamWe(chrRamWe)
  );

  mapper_datapath #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_EFF)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cpuAddr   (cpuAddr),
    .vidAddr   (vidAddr),
    .prgAddr   (prgAddr),
    .prgHit    (prgHit),
    .chrAddr   (chrAddr),
    .chrHit    (chrHit),
    .mirrorVert(mirrorVert)
  );

  // R10
  ram_we_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    chrRamWe |-> (chrHit && vidWrEn && CHR_IS_RAM));

endmodule

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        cpuWrEn = 1'b0;
  logic [13:0] vidAddr = '0;
  logic        vidWrEn = 1'b0;

  logic [15:0] prgAddr, prgAddrR;
  logic [13:0] chrAddr;
  logic [12:0] chrAddrR;
  logic prgHit, chrHit, chrRamWe, mirrorVert;
  logic prgHitR, chrHitR, chrRamWeR, mirrorVertR;

  int checks = 0;
  int errors = 0;

  int mChr[6];
  int mPrg[3];
  int mCtl;

  always #10 clk = ~clk;

  cart_bank_mapper #(.PRG_BANKS(8), .CHR_BANKS_1K(16), .CHR_IS_RAM(1'b0)) dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData), .cpuWrEn(cpuWrEn),
    .vidAddr(vidAddr), .vidWrEn(vidWrEn), .prgAddr(prgAddr), .prgHit(prgHit),
    .chrAddr(chrAddr), .chrHit(chrHit), .chrRamWe(chrRamWe), .mirrorVert(mirrorVert));

  cart_bank_mapper #(.PRG_BANKS(8), .CHR_BANKS_1K(16), .CHR_IS_RAM(1'b1)) dutRam (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData), .cpuWrEn(cpuWrEn),
    .vidAddr(vidAddr), .vidWrEn(vidWrEn), .prgAddr(prgAddrR), .prgHit(prgHitR),
    .chrAddr(chrAddrR), .chrHit(chrHitR), .chrRamWe(chrRamWeR), .mirrorVert(mirrorVertR));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int expPrg(input int a);
    int bank;
    bank = (((a >> 13) & 3) == 3) ? 7 : (mPrg[(a >> 13) & 3] % 8);
    return bank * 8192 + (a & 16'h1FFF);
  endfunction

  function automatic int expChr(input int a, input int nb1k);
    int s, bank;
    s = a ^ (((mCtl >> 1) & 1) * 16'h1000);
    if ((s & 16'h1000) == 0) begin
      bank = (mChr[(s >> 11) & 1] >> 1) % (nb1k / 2);
      return bank * 2048 + (a & 16'h07FF);
    end
    bank = mChr[2 + ((s >> 10) & 3)] % nb1k;
    return bank * 1024 + (a & 16'h03FF);
  endfunction

  task automatic resetModel();
    mChr = '{0, 2, 4, 5, 6, 7};
    mPrg = '{0, 1, 2};
    mCtl = 0;
  endtask

  task automatic cpuWrite(input int a, input int d);
    @(negedge clk);
    cpuAddr = 16'(a);
    cpuData = 8'(d);
    cpuWrEn = 1'b1;
    @(posedge clk);
    #1 cpuWrEn = 1'b0;
    if (a >= 16'h7EF0 && a <= 16'h7EF5) mChr[a - 16'h7EF0] = d;
    else if (a == 16'h7EF6) mCtl = d & 3;
    else if (a >= 16'h7EFA && a <= 16'h7EFC) mPrg[a - 16'h7EFA] = d >> 2;
  endtask

  task automatic sweep(input string req);
    for (int k = 0; k < 256; k++) begin
      int ca, va;
      ca = (k * 16'h0101 + k) & 16'hFFFF;
      va = (k * 16'h0043) & 16'h3FFF;
      @(negedge clk);
      cpuAddr = 16'(ca);
      vidAddr = 14'(va);
      #2;
      chk({req, " R9 prgHit"}, int'(prgHit), (ca >= 16'h8000) ? 1 : 0);
      chk({req, " R9 chrHit"}, int'(chrHit), (va < 16'h2000) ? 1 : 0);
      if (ca >= 16'h8000) begin
        chk({req, " R4 R5 prgAddr"}, int'(prgAddr), expPrg(ca));
        chk({req, " R8 prgAddr ram cfg"}, int'(prgAddrR), expPrg(ca));
      end
      if (va < 16'h2000) begin
        chk({req, " R6 chrAddr"}, int'(chrAddr), expChr(va, 16));
        chk({req, " R8 chrAddr ram cfg"}, int'(chrAddrR), expChr(va, 8));
      end
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    resetModel();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 mirror at reset", int'(mirrorVert), 0);
    rstN = 1'b1;
    sweep("R1 reset map");

    // R2 R4 R8: load every register, several beyond the bank counts
    cpuWrite(16'h7EF0, 8'h13);
    cpuWrite(16'h7EF1, 8'h2A);
    cpuWrite(16'h7EF2, 8'h1F);
    cpuWrite(16'h7EF3, 8'h33);
    cpuWrite(16'h7EF4, 8'h08);
    cpuWrite(16'h7EF5, 8'hFE);
    cpuWrite(16'h7EFA, 8'hFC);
    cpuWrite(16'h7EFB, 8'h15);
    cpuWrite(16'h7EFC, 8'h28);
    cpuWrite(16'h7EF6, 8'hFD);
    #1 chk("R3 mirror vertical", int'(mirrorVert), 1);
    sweep("R2 R8 loaded");

    // R7: swap halves, mirror back to horizontal
    cpuWrite(16'h7EF6, 8'h02);
    #1 chk("R3 mirror horizontal", int'(mirrorVert), 0);
    sweep("R7 swapped");

    // R11: stray writes
    cpuWrite(16'h7EF7, 8'hAA);
    cpuWrite(16'h7EF8, 8'hAA);
    cpuWrite(16'h7EF9, 8'hAA);
    cpuWrite(16'h7EFD, 8'hAA);
    cpuWrite(16'h7EFE, 8'hAA);
    cpuWrite(16'h7EFF, 8'hAA);
    cpuWrite(16'h8EF0, 8'hAA);
    cpuWrite(16'hFEF6, 8'hAB);
    cpuWrite(16'h7FF0, 8'hAA);
    #1 chk("R11 mirror unchanged", int'(mirrorVert), 0);
    sweep("R11 stray");

    // R10: write gating on the video bus
    cpuWrite(16'h7EF6, 8'h00);
    @(negedge clk);
    vidAddr = 14'h0123;
    vidWrEn = 1'b1;
    #2;
    chk("R10 rom cfg no we", int'(chrRamWe), 0);
    chk("R10 ram cfg we", int'(chrRamWeR), 1);
    vidAddr = 14'h2100;
    #2;
    chk("R10 ram cfg outside space", int'(chrRamWeR), 0);
    vidWrEn = 1'b0;
    vidAddr = 14'h0123;
    #2;
    chk("R10 ram cfg no strobe", int'(chrRamWeR), 0);

    // R12: register write and translation through it in one cycle
    @(negedge clk);
    cpuAddr = 16'h7EF0;
    cpuData = 8'h0C;
    cpuWrEn = 1'b1;
    vidAddr = 14'h0010;
    vidWrEn = 1'b1;
    #2;
    chk("R12 old bank before edge", int'(chrAddr), expChr(16'h0010, 16));
    chk("R12 ram we same cycle", int'(chrRamWeR), 1);
    @(posedge clk);
    #1;
    cpuWrEn = 1'b0;
    vidWrEn = 1'b0;
    mChr[0] = 8'h0C;
    #1;
    chk("R12 new bank after edge", int'(chrAddr), expChr(16'h0010, 16));
    chk("R12 new bank ram cfg", int'(chrAddrR), expChr(16'h0010, 8));
    chk("R12 value", int'(chrAddr), 6 * 2048 + 16'h0010);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule